// File: doc/BRIEF.md
# Selectable Controller Clock Divider

This block derives a slower controller clock from a fast source clock. A 3-bit ratio code picks one of eight division ratios. Some of the ratios are not powers of two. The block produces two outputs: a one-cycle strobe at every rising edge of the divided clock, and a registered level that shows the divided clock itself. Downstream logic clocked by the source clock uses the strobe as a clock enable.

A separate divider reset holds the counter at zero. The ratio code is captured only while that reset is high. Because of this, a ratio change always takes effect from a clean start and can never cut a period short. An enable input gates both outputs. A bypass select replaces the divided clock with an external pin clock, which is first brought into the source domain through a synchronizer. The captured code and the registered enable are returned on status outputs so that software can read back what it wrote.

Top module: `ctl_clk_divider`

## Requirements
- R1: Ratio codes 0 through 7 divide by 1, 2, 4, 6, 8, 16, 24 and 32 respectively. In divided mode with enable high, `div_strobe_o` pulses for one cycle every N source cycles.
- R2: For a ratio N of 2 or more, `div_clk_o` rises in the same cycle as the strobe and stays high for exactly N/2 of every N cycles.
- R3: If `clk_en_i` is low at a clock edge, both `div_strobe_o` and `div_clk_o` are low in the following cycle.
- R4: While `div_rst_i` is high in divided mode, both outputs stay low. After release, the first strobe appears N cycles after the first edge at which `div_rst_i` is sampled low.
- R5: `ratio_sel_i` is captured only at edges where `div_rst_i` is high, and `sel_status_o` shows the captured code. A change of `ratio_sel_i` while `div_rst_i` is low has no effect on the status or on the period.
- R6: `en_status_o` equals `clk_en_i` delayed by one cycle.
- R7: With code 0, the strobe is high in every cycle and `div_clk_o` is held high, both while enabled and running.
- R8: With `bypass_i` high, `div_clk_o` follows `ext_clk_i` delayed by SYNC_STAGES cycles and gated by the enable. The strobe marks each rising edge of the synchronized pin clock.
- R9: While `rst_i` is high, all outputs are driven to 0 from the next cycle, and the captured code becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_i | input | 1 | Synchronous active-high system reset |
| div_rst_i | input | 1 | Divider reset; holds the counter and opens ratio capture |
| clk_en_i | input | 1 | Output enable for the controller clock |
| ratio_sel_i | input | 3 | Ratio code |
| bypass_i | input | 1 | 1 selects the external pin clock |
| ext_clk_i | input | 1 | External pin clock, asynchronous |
| div_strobe_o | output | 1 | One-cycle strobe at each rising edge of the output clock |
| div_clk_o | output | 1 | Gated output clock level |
| sel_status_o | output | 3 | Captured ratio code |
| en_status_o | output | 1 | Registered enable |

## Verification
The assertions take the following for granted about the inputs:
- The select code only matters while the divider reset is high.
- The bypass select is changed only while the divider reset is high or while the enable is low.
- The pin clock is slow compared with the source clock, so the synchronizer sees every level.

The stimulus follows these rules. It moves `ratio_sel_i` outside divider reset only to exercise R5. It toggles the pin clock no faster than once every five source cycles. It changes every input on the falling edge, away from the sampling edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int SEL_W     = 3;
  localparam int MAX_RATIO = 32;
  localparam int CNT_W     = $clog2(MAX_RATIO);
  localparam int RATIO_W   = CNT_W + 1;

  typedef logic [SEL_W-1:0]   sel_t;
  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  function automatic ratio_t code_to_ratio(input sel_t code);
    ratio_t r;
    case (code)
      3'd0:    r = RATIO_W'(1);
      3'd1:    r = RATIO_W'(2);
      3'd2:    r = RATIO_W'(4);
      3'd3:    r = RATIO_W'(6);
      3'd4:    r = RATIO_W'(8);
      3'd5:    r = RATIO_W'(16);
      3'd6:    r = RATIO_W'(24);
      default: r = RATIO_W'(32);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clkdiv_ratio_latch.sv
module clkdiv_ratio_latch
  import clkdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   capture_i,
  input  sel_t   sel_i,
  output sel_t   sel_q_o,
  output ratio_t ratio_o
);
  sel_t   sel_q;
  ratio_t ratio_q;

  // capture only while the divider is held in reset
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_q   <= '0;
      ratio_q <= RATIO_W'(1);
    end else if (capture_i) begin
      sel_q   <= sel_i;
      ratio_q <= code_to_ratio(sel_i);
    end
  end

  assign sel_q_o = sel_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   run_i,
  input  ratio_t ratio_i,
  output logic   wrap_o,
  output logic   level_nxt_o
);
  cnt_t   cnt_q;
  logic   armed_q;
  cnt_t   cnt_nxt;
  cnt_t   last;
  ratio_t half;
  logic   armed_nxt;

  assign last    = CNT_W'(ratio_i - RATIO_W'(1));
  assign half    = ratio_i >> 1;
  assign wrap_o  = run_i && (cnt_q == last);

  always_comb begin
    if (!run_i || wrap_o) cnt_nxt = '0;
    else                  cnt_nxt = cnt_q + CNT_W'(1);
  end

  // armed after the first full period, so no early high phase
  assign armed_nxt = run_i && (armed_q || wrap_o);

  always_comb begin
    if (ratio_i == RATIO_W'(1)) level_nxt_o = run_i;
    else level_nxt_o = armed_nxt && ({1'b0, cnt_nxt} < half);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      armed_q <= armed_nxt;
    end
  end
endmodule

// File: rtl/clkdiv_ext_sync.sv
module clkdiv_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ext_i,
  output logic ext_s_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= ext_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= {sync_q[STAGES-2:0], ext_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b0;
    else       prev_q <= sync_q[STAGES-1];
  end

  assign ext_s_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] && !prev_q;
endmodule

// File: rtl/ctl_clk_divider.sv
module ctl_clk_divider
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             div_rst_i,
  input  logic             clk_en_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  input  logic             bypass_i,
  input  logic             ext_clk_i,
  output logic             div_strobe_o,
  output logic             div_clk_o,
  output logic [SEL_W-1:0] sel_status_o,
  output logic             en_status_o
);
  ratio_t ratio;
  sel_t   sel_q;
  logic   wrap;
  logic   level_nxt;
  logic   ext_s;
  logic   ext_rise;
  logic   strobe_q;
  logic   clk_q;
  logic   en_q;

  clkdiv_ratio_latch u_latch (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .capture_i (div_rst_i),
    .sel_i     (ratio_sel_i),
    .sel_q_o   (sel_q),
    .ratio_o   (ratio)
  );

  clkdiv_counter u_cnt (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .run_i       (!div_rst_i),
    .ratio_i     (ratio),
    .wrap_o      (wrap),
    .level_nxt_o (level_nxt)
  );

  clkdiv_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .ext_i   (ext_clk_i),
    .ext_s_o (ext_s),
    .rise_o  (ext_rise)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      strobe_q <= 1'b0;
      clk_q    <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      strobe_q <= clk_en_i && (bypass_i ? ext_rise : wrap);
      clk_q    <= clk_en_i && (bypass_i ? ext_s : level_nxt);
      en_q     <= clk_en_i;
    end
  end

  assign div_strobe_o = strobe_q;
  assign div_clk_o    = clk_q;
  assign sel_status_o = sel_q;
  assign en_status_o  = en_q;
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
  import clkdiv_pkg::*;
(
  input logic       clk_i,
  input logic       rst_i,
  input logic       div_rst_i,
  input logic       clk_en_i,
  input logic       bypass_i,
  input logic       div_strobe_o,
  input logic       div_clk_o,
  input sel_t       sel_status_o,
  input logic       en_status_o
);
  p_gate_off_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !clk_en_i |=> (!div_strobe_o && !div_clk_o));

  p_held_quiet_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (div_rst_i && !bypass_i) |=> (!div_strobe_o && !div_clk_o));

  p_sel_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !div_rst_i |=> $stable(sel_status_o));

  p_en_high_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    clk_en_i |=> en_status_o);

  p_en_low_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !clk_en_i |=> !en_status_o);

  p_reset_clear_r9: assert property (@(posedge clk_i)
    rst_i |=> (!div_strobe_o && !div_clk_o && !en_status_o && sel_status_o == '0));
endmodule

bind ctl_clk_divider clkdiv_checker u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .div_rst_i    (div_rst_i),
  .clk_en_i     (clk_en_i),
  .bypass_i     (bypass_i),
  .div_strobe_o (div_strobe_o),
  .div_clk_o    (div_clk_o),
  .sel_status_o (sel_status_o),
  .en_status_o  (en_status_o)
);

// File: tb/ctl_clk_divider_tb_top.sv
`timescale 1ns/1ps
module ctl_clk_divider_tb_top;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       drst = 1'b1;
  logic       en = 1'b1;
  logic [2:0] sel = 3'd0;
  logic       byp = 1'b0;
  logic       ext = 1'b0;
  logic       strobe, dclk, en_st;
  logic [2:0] sel_st;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  ctl_clk_divider #(.SYNC_STAGES(S)) dut_i (
    .clk_i(clk), .rst_i(rst), .div_rst_i(drst), .clk_en_i(en),
    .ratio_sel_i(sel), .bypass_i(byp), .ext_clk_i(ext),
    .div_strobe_o(strobe), .div_clk_o(dclk),
    .sel_status_o(sel_st), .en_status_o(en_st)
  );

  // ratio table as stated in R1
  int ratio_tab[8] = '{1, 2, 4, 6, 8, 16, 24, 32};

  // reference model state
  int m_code = 0;
  int m_k = 0;
  bit hist[0:S+1];
  bit e_strobe = 0, e_clk = 0, e_en = 0;
  int e_sel = 0;
  bit e_byp = 0, e_en_in = 0;
  int e_code_used = 0;

  always @(posedge clk) begin
    int n;
    bit wrap, lvl, rise;
    cyc++;
    if (rst) begin
      m_code = 0; m_k = 0;
      for (int i = 0; i <= S+1; i++) hist[i] = 0;
      e_strobe = 0; e_clk = 0; e_en = 0; e_sel = 0;
    end else begin
      if (drst) begin m_code = int'(sel); m_k = 0; end
      else m_k++;
      n = ratio_tab[m_code];
      for (int i = S+1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = ext;
      rise = hist[S] && !hist[S+1];
      wrap = !drst && m_k >= 1 && (m_k % n == 0);
      if (n == 1) lvl = !drst;
      else        lvl = !drst && m_k >= n && ((m_k % n) < n/2);
      e_strobe = en && (byp ? rise : wrap);
      e_clk    = en && (byp ? hist[S] : lvl);
      e_en     = en;
      e_sel    = m_code;
    end
    e_byp = byp; e_en_in = en; e_code_used = m_code;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cyc > 0) begin
      check(e_byp ? "R8 strobe" : (e_code_used == 0 ? "R7 strobe" : "R1 strobe"),
            int'(strobe), int'(e_strobe));
      check(e_byp ? "R8 clk" : (!e_en_in ? "R3 clk" : "R2 clk"), int'(dclk), int'(e_clk));
      check("R6 en_status", int'(en_st), int'(e_en));
      check("R5 sel_status", int'(sel_st), e_sel);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic load_code(int code);
    @(negedge clk);
    drst = 1'b1; sel = 3'(code);
    repeat (3) @(negedge clk);
    drst = 1'b0;
  endtask

  // R4 first period, R1 period, R2 high time
  task automatic measure(int code);
    int n, gap, hi;
    n = ratio_tab[code];
    load_code(code);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!strobe && gap < 100);
    check("R4 first strobe delay", gap, n);
    gap = 0; hi = 0;
    do begin @(negedge clk); gap++; hi += int'(dclk); end while (!strobe && gap < 100);
    check(code == 0 ? "R7 period" : "R1 period", gap, n);
    check(code == 0 ? "R7 high time" : "R2 high time", hi, (n == 1) ? 1 : n/2);
  endtask

  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    check("R9 strobe in reset", int'(strobe), 0);
    check("R9 clk in reset", int'(dclk), 0);
    check("R9 en_status in reset", int'(en_st), 0);
    check("R9 sel in reset", int'(sel_st), 0);
    rst = 1'b0;

    for (int c = 0; c < 8; c++) measure(c);

    // R5: change select outside divider reset
    measure(3);
    @(negedge clk); sel = 3'd7;
    repeat (20) @(negedge clk);
    check("R5 select ignored", int'(sel_st), 3);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); cnt += int'(strobe); end
    check("R5 period kept", cnt, 10);

    // R3: enable low
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); cnt += int'(strobe) + int'(dclk); end
    check("R3 gated outputs", cnt, 0);
    en = 1'b1;

    // R4: held in divider reset
    @(negedge clk); drst = 1'b1; sel = 3'd1;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); cnt += int'(strobe) + int'(dclk); end
    check("R4 held quiet", cnt, 0);

    // R8: bypass with pin clock of period 10
    byp = 1'b1;
    begin
      int last, seen;
      last = -1; seen = 0;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (i % 5 == 0) ext = ~ext;
        if (strobe) begin
          if (last >= 0) begin check("R8 pin period", i - last, 10); seen++; end
          last = i;
        end
      end
      check("R8 strobes seen", int'(seen >= 5), 1);
    end
    byp = 1'b0; ext = 1'b0;
    @(negedge clk); drst = 1'b0;
    repeat (10) @(negedge clk);

    // R9: reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 sel cleared", int'(sel_st), 0);
    check("R9 strobe cleared", int'(strobe), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule